// File: doc/BRIEF.md
# Interrupt Claim and Retire Interface

This block is the register window through which one processor claims and retires interrupts. Software reads a claim register to take the highest-priority pending interrupt. It later writes that interrupt's number to a retire register. Around those two operations sit a CPU enable bit, an 8-bit priority mask, a reserved grouping register, a readback of the priority now in service and a readback of the best candidate. A separate priority resolver selects the candidate interrupt. Each source's priority, line level, trigger type, delivery model, enable and targeting arrive as inputs. The pending bits live in shared storage outside the block, and the block drives that storage through one clear request and one set request.

Nesting uses a per-interrupt link that records which interrupt was in service when this one was claimed. Retiring the interrupt in service restores its link. Retiring an interrupt deeper in the nest removes it from the chain: a small state machine follows one link per cycle, and the register bus stalls until it finishes. When a level-sensitive source is retired while its line is still high, the block asks the shared storage to mark it pending again.

The register bus is 10 bits wide and word addressed. The word index times four gives the byte offset: 0 control, 1 mask, 2 grouping, 3 claim, 4 retire, 5 service priority, 6 best candidate, and 7 is unused. A transfer is accepted in any cycle where `bus_valid` and `bus_ready` are both high. Read data is valid in the same cycle.

Top module: `irq_cpu_iface`

## Requirements
- R1: After reset, the control word reads 0, the mask reads 0xF0, the service priority reads 0x100, the best candidate reads 1023 and `irq_o` is low.
- R2: Word 0 keeps only bit 0, which is the CPU enable. Word 1 keeps the low 8 bits. Word 2 and word 7 read 0 and ignore writes. Writes to the read-only words 3, 5 and 6 change nothing.
- R3: The best candidate (word 6) is `best_id` when the CPU is enabled, `best_id` is not 1023 and that source's priority is at most the mask. Otherwise it reads 1023.
- R4: `irq_o` is high exactly when the best candidate is not 1023 and its priority is strictly below the service priority.
- R5: A claim read returns 1023 and changes no state when the best candidate is 1023 or its priority is not strictly below the service priority.
- R6: A successful claim returns the candidate's number and makes it the interrupt in service, with the service priority equal to its priority. In the same cycle it raises `pend_clr_valid` for that number, and `pend_clr_all` is high when the source's model bit is 1 (clear for every CPU) and low when it is 0 (clear for this CPU only).
- R7: Retiring the interrupt in service restores the interrupt that was in service when it was claimed. The service priority becomes that interrupt's priority, or 0x100 when the restored number is 1023.
- R8: Retiring an interrupt that is nested below the one in service removes it from the chain and leaves the service priority unchanged. `bus_ready` is low in the cycle after that write and stays low until the chain walk ends. Later retirements then unwind past the removed entry.
- R9: A retire write whose number is NIRQ or more (1023 included), or one made while nothing is in service, has no effect at all.
- R10: A valid retire of a source that is level-sensitive (edge bit 0), enabled, targeted at this CPU and whose line is high raises `pend_set_valid` with that number in the same cycle. If any of those conditions is false, no set request is made.
- R11: Each accepted claim read makes exactly one clear request, which carries the same number as the read data. A rejected claim makes none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register transfer request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word index of the register |
| bus_wdata | input | 10 | Write data |
| bus_ready | output | 1 | Transfer accepted when high with bus_valid |
| bus_rdata | output | 10 | Read data, valid in the accepting cycle |
| best_id | input | 10 | Resolver's best pending source, 1023 for none |
| src_prio | input | NIRQ*8 | Per-source priority, source i at bits [8i+7:8i] |
| src_level | input | NIRQ | Per-source line level |
| src_edge | input | NIRQ | 1 = edge-triggered, 0 = level-sensitive |
| src_model | input | NIRQ | 1 = claim clears pending for every CPU |
| src_enable | input | NIRQ | Source enabled for this CPU |
| src_target | input | NIRQ | Source routed to this CPU |
| pend_clr_valid | output | 1 | Clear-pending request |
| pend_clr_id | output | 10 | Source to clear |
| pend_clr_all | output | 1 | Clear for all CPUs rather than this one |
| pend_set_valid | output | 1 | Set-pending request for this CPU |
| pend_set_id | output | 10 | Source to set |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench sweeps all 256 mask values against three source priorities. A design that compares the mask with < rather than <= fails where the two values are equal. The bench nests three interrupts and retires them in all six orders. A wrong splice, one that restores the wrong link or loses the entry below, shows up as a wrong service priority. A walker that does not stall shows up as `bus_ready` staying high. The bench also tries a claim at a priority equal to the one in service, which must be refused. It retires level sources with the line high and low, disabled or routed elsewhere, and edge sources, expecting a re-pend request only in the first case. It writes out-of-range and spurious retire numbers, which a design that does not bound-check would use to corrupt the chain.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 8;
  localparam int DATA_W = 10;
  localparam logic [ID_W-1:0]   NO_ID     = 10'd1023;
  localparam logic [PRIO_W:0]   IDLE_PRIO = 9'h100;
  localparam logic [PRIO_W-1:0] MASK_RST  = 8'hF0;

  typedef enum logic [2:0] {
    RG_CTRL  = 3'd0,
    RG_MASK  = 3'd1,
    RG_GROUP = 3'd2,
    RG_CLAIM = 3'd3,
    RG_RETIRE= 3'd4,
    RG_SPRIO = 3'd5,
    RG_BEST  = 3'd6,
    RG_NONE  = 3'd7
  } reg_sel_e;

  // Priority extended by one bit; "nothing" sorts above every real priority.
  function automatic logic [PRIO_W:0] widen_prio(input logic [PRIO_W-1:0] p,
                                                 input logic [ID_W-1:0] id);
    return (id == NO_ID) ? IDLE_PRIO : {1'b0, p};
  endfunction

  function automatic logic preempts(input logic [PRIO_W:0] cand,
                                    input logic [PRIO_W:0] serving);
    return cand < serving;
  endfunction
endpackage

// File: rtl/cpuif_regs.sv
module cpuif_regs import cpuif_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_acc,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ID_W-1:0]   claim_word,
  input  logic [PRIO_W:0]   serve_prio,
  input  logic [ID_W-1:0]   best_vis,
  output logic              cpu_en,
  output logic [PRIO_W-1:0] pmask,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_en <= 1'b0;
      pmask  <= MASK_RST;
    end else if (wr_acc) begin
      if (sel == RG_CTRL) cpu_en <= wdata[0];
      if (sel == RG_MASK) pmask  <= wdata[PRIO_W-1:0];
    end
  end

  always_comb begin
    unique case (sel)
      RG_CTRL:  rdata = DATA_W'(cpu_en);
      RG_MASK:  rdata = DATA_W'(pmask);
      RG_CLAIM: rdata = DATA_W'(claim_word);
      RG_SPRIO: rdata = DATA_W'(serve_prio);
      RG_BEST:  rdata = DATA_W'(best_vis);
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/cpuif_pend_view.sv
module cpuif_pend_view import cpuif_pkg::*; #(
  parameter int NIRQ = 32
) (
  input  logic [NIRQ*PRIO_W-1:0] src_prio,
  input  logic [ID_W-1:0]        best_id,
  input  logic                   cpu_en,
  input  logic [PRIO_W-1:0]      pmask,
  input  logic [PRIO_W:0]        serve_prio,
  output logic [ID_W-1:0]        best_vis,
  output logic [PRIO_W:0]        best_prio,
  output logic                   can_claim
);
  localparam int IDX_W = (NIRQ > 1) ? $clog2(NIRQ) : 1;

  function automatic logic [PRIO_W-1:0] prio_of(input logic [ID_W-1:0] id);
    return src_prio[int'(id[IDX_W-1:0])*PRIO_W +: PRIO_W];
  endfunction

  logic [PRIO_W-1:0] raw_prio;
  logic              visible;

  always_comb begin
    raw_prio  = prio_of(best_id);
    visible   = cpu_en && (best_id != NO_ID) && (raw_prio <= pmask);
    best_vis  = visible ? best_id : NO_ID;
    best_prio = widen_prio(raw_prio, best_vis);
    can_claim = visible && preempts(best_prio, serve_prio);
  end
endmodule

// File: rtl/cpuif_nest.sv
module cpuif_nest import cpuif_pkg::*; #(
  parameter int NIRQ = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ack_take,
  input  logic [ID_W-1:0]        ack_id,
  input  logic [PRIO_W:0]        ack_prio,
  input  logic                   eoi_take,
  input  logic [ID_W-1:0]        eoi_id,
  input  logic [NIRQ*PRIO_W-1:0] src_prio,
  output logic [ID_W-1:0]        running_id,
  output logic [PRIO_W:0]        serve_prio,
  output logic [ID_W-1:0]        run_link,
  output logic                   walk_busy,
  output logic                   walk_splice
);
  localparam int IDX_W = (NIRQ > 1) ? $clog2(NIRQ) : 1;

  function automatic logic [PRIO_W-1:0] prio_of(input logic [ID_W-1:0] id);
    return src_prio[int'(id[IDX_W-1:0])*PRIO_W +: PRIO_W];
  endfunction

  logic [ID_W-1:0] links [NIRQ];
  logic [ID_W-1:0] walk_cur, walk_tgt, walk_next;
  logic [PRIO_W:0] pop_prio;
  logic            walk_end;

  assign run_link    = links[running_id[IDX_W-1:0]];
  assign walk_next   = links[walk_cur[IDX_W-1:0]];
  assign walk_splice = walk_busy && (walk_next == walk_tgt);
  assign walk_end    = walk_busy && (walk_next == NO_ID);
  assign pop_prio    = widen_prio(prio_of(run_link), run_link);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NIRQ; i++) links[i] <= NO_ID;
      running_id <= NO_ID;
      serve_prio <= IDLE_PRIO;
      walk_busy  <= 1'b0;
      walk_cur   <= NO_ID;
      walk_tgt   <= NO_ID;
    end else if (ack_take) begin
      links[ack_id[IDX_W-1:0]] <= running_id;
      running_id <= ack_id;
      serve_prio <= ack_prio;
    end else if (eoi_take) begin
      if (eoi_id == running_id) begin
        running_id <= run_link;
        serve_prio <= pop_prio;
      end else begin
        walk_busy <= 1'b1;
        walk_cur  <= running_id;
        walk_tgt  <= eoi_id;
      end
    end else if (walk_busy) begin
      if (walk_end) begin
        walk_busy <= 1'b0;
      end else if (walk_splice) begin
        links[walk_cur[IDX_W-1:0]] <= links[walk_tgt[IDX_W-1:0]];
        walk_busy <= 1'b0;
      end else begin
        walk_cur <= walk_next;
      end
    end
  end
endmodule

// File: rtl/irq_cpu_iface.sv
module irq_cpu_iface import cpuif_pkg::*; #(
  parameter int NIRQ = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_valid,
  input  logic                   bus_write,
  input  logic [2:0]             bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic                   bus_ready,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic [ID_W-1:0]        best_id,
  input  logic [NIRQ*PRIO_W-1:0] src_prio,
  input  logic [NIRQ-1:0]        src_level,
  input  logic [NIRQ-1:0]        src_edge,
  input  logic [NIRQ-1:0]        src_model,
  input  logic [NIRQ-1:0]        src_enable,
  input  logic [NIRQ-1:0]        src_target,
  output logic                   pend_clr_valid,
  output logic [ID_W-1:0]        pend_clr_id,
  output logic                   pend_clr_all,
  output logic                   pend_set_valid,
  output logic [ID_W-1:0]        pend_set_id,
  output logic                   irq_o
);
  localparam int IDX_W = (NIRQ > 1) ? $clog2(NIRQ) : 1;
  localparam logic [ID_W-1:0] NIRQ_ID = ID_W'(NIRQ);

  reg_sel_e          sel;
  logic              rd_acc, wr_acc, ack_rd, eoi_wr, ack_take, eoi_take;
  logic              cpu_en, can_claim, walk_busy, walk_splice;
  logic [PRIO_W-1:0] pmask;
  logic [PRIO_W:0]   serve_prio, best_prio;
  logic [ID_W-1:0]   best_vis, running_id, run_link, eoi_id, claim_word;
  logic [IDX_W-1:0]  eoi_idx, best_idx;

  assign sel       = reg_sel_e'(bus_addr);
  assign bus_ready = !walk_busy;
  assign rd_acc    = bus_valid && bus_ready && !bus_write;
  assign wr_acc    = bus_valid && bus_ready && bus_write;
  assign ack_rd    = rd_acc && (sel == RG_CLAIM);
  assign eoi_wr    = wr_acc && (sel == RG_RETIRE);
  assign eoi_id    = bus_wdata[ID_W-1:0];
  assign eoi_idx   = eoi_id[IDX_W-1:0];
  assign best_idx  = best_vis[IDX_W-1:0];
  assign ack_take  = ack_rd && can_claim;
  assign eoi_take  = eoi_wr && (eoi_id < NIRQ_ID) && (running_id != NO_ID);
  assign claim_word = can_claim ? best_vis : NO_ID;

  assign pend_clr_valid = ack_take;
  assign pend_clr_id    = best_vis;
  assign pend_clr_all   = src_model[best_idx];
  assign pend_set_valid = eoi_take && !src_edge[eoi_idx] && src_enable[eoi_idx]
                          && src_level[eoi_idx] && src_target[eoi_idx];
  assign pend_set_id    = eoi_id;
  assign irq_o          = (best_vis != NO_ID) && preempts(best_prio, serve_prio);

  cpuif_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .sel(sel), .wdata(bus_wdata),
    .claim_word(claim_word), .serve_prio(serve_prio), .best_vis(best_vis),
    .cpu_en(cpu_en), .pmask(pmask), .rdata(bus_rdata)
  );

  cpuif_pend_view #(.NIRQ(NIRQ)) u_view (
    .src_prio(src_prio), .best_id(best_id), .cpu_en(cpu_en), .pmask(pmask),
    .serve_prio(serve_prio), .best_vis(best_vis), .best_prio(best_prio),
    .can_claim(can_claim)
  );

  cpuif_nest #(.NIRQ(NIRQ)) u_nest (
    .clk(clk), .rst_n(rst_n), .ack_take(ack_take), .ack_id(best_vis),
    .ack_prio(best_prio), .eoi_take(eoi_take), .eoi_id(eoi_id),
    .src_prio(src_prio), .running_id(running_id), .serve_prio(serve_prio),
    .run_link(run_link), .walk_busy(walk_busy), .walk_splice(walk_splice)
  );
endmodule

// File: rtl/cpuif_checker.sv
module cpuif_checker import cpuif_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              ack_rd,
  input logic              ack_take,
  input logic              eoi_wr,
  input logic              eoi_take,
  input logic [ID_W-1:0]   eoi_id,
  input logic [ID_W-1:0]   best_vis,
  input logic [ID_W-1:0]   running_id,
  input logic [ID_W-1:0]   run_link,
  input logic              walk_busy,
  input logic              walk_splice,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              pend_clr_valid,
  input logic [ID_W-1:0]   pend_clr_id,
  input logic              pend_set_valid,
  input logic              irq_o,
  input logic              cpu_en
);
  AST_ACK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> running_id == $past(best_vis)); // R6
  AST_ACK_REFUSE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !ack_take) |-> bus_rdata == DATA_W'(NO_ID)); // R5
  AST_ACK_REFUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !ack_take) |=> $stable(running_id)); // R5
  AST_TOP_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_take && eoi_id == running_id) |=> running_id == $past(run_link)); // R7
  AST_WALK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    walk_busy |=> $stable(running_id)); // R8
  AST_SPLICE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    walk_splice |=> !walk_busy); // R8
  AST_EOI_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !eoi_take) |=> ($stable(running_id) && !walk_busy)); // R9
  AST_REPEND_ON_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    pend_set_valid |-> eoi_take); // R10
  AST_CLR_MATCHES_READ: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr_valid |-> (ack_rd && pend_clr_id == bus_rdata)); // R11
  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pend_set_valid, pend_clr_valid})); // R11
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> cpu_en); // R4
endmodule

bind irq_cpu_iface cpuif_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ack_rd(ack_rd), .ack_take(ack_take),
  .eoi_wr(eoi_wr), .eoi_take(eoi_take), .eoi_id(eoi_id), .best_vis(best_vis),
  .running_id(running_id), .run_link(run_link), .walk_busy(walk_busy),
  .walk_splice(walk_splice), .bus_rdata(bus_rdata),
  .pend_clr_valid(pend_clr_valid), .pend_clr_id(pend_clr_id),
  .pend_set_valid(pend_set_valid), .irq_o(irq_o), .cpu_en(cpu_en)
);

// File: tb/irq_cpu_iface_bench.sv
`timescale 1ns/1ps
module irq_cpu_iface_bench;
  localparam int NB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       bus_valid = 1'b0, bus_write = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [9:0] bus_wdata = '0;
  logic       bus_ready;
  logic [9:0] bus_rdata;
  logic [9:0] best_id;
  logic [NB*8-1:0] src_prio;
  logic [NB-1:0] pend_m, en_m, lvl_m, edge_m, model_m, tgt_m;
  logic [7:0] prio_m [NB];
  logic       pend_clr_valid, pend_clr_all, pend_set_valid, irq_o;
  logic [9:0] pend_clr_id, pend_set_id;

  int nchk = 0, nerr = 0, clr_count = 0, exp_acks = 0;
  logic       last_clr, last_clr_all, last_set, last_busy;
  logic [9:0] last_clr_id, last_set_id;

  irq_cpu_iface #(.NIRQ(NB)) u_irq_cpu_iface (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .best_id(best_id), .src_prio(src_prio),
    .src_level(lvl_m), .src_edge(edge_m), .src_model(model_m),
    .src_enable(en_m), .src_target(tgt_m), .pend_clr_valid(pend_clr_valid),
    .pend_clr_id(pend_clr_id), .pend_clr_all(pend_clr_all),
    .pend_set_valid(pend_set_valid), .pend_set_id(pend_set_id), .irq_o(irq_o)
  );

  // Bench stand-in for the resolver: lowest priority value wins, lower index on ties.
  always_comb begin
    logic [8:0] bp;
    best_id = 10'd1023;
    bp = 9'h100;
    for (int i = 0; i < NB; i++) begin
      src_prio[i*8 +: 8] = prio_m[i];
      if (pend_m[i] && en_m[i] && ({1'b0, prio_m[i]} < bp)) begin
        bp = {1'b0, prio_m[i]};
        best_id = 10'(i);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [9:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_wdata = '0;
    #1;
    while (!bus_ready) begin @(negedge clk); #1; end
    d = bus_rdata;
    last_clr = pend_clr_valid; last_clr_id = pend_clr_id; last_clr_all = pend_clr_all;
    @(posedge clk); #1;
    bus_valid = 1'b0;
    if (last_clr) begin clr_count++; pend_m[last_clr_id[2:0]] = 1'b0; end
  endtask

  task automatic wr(input logic [2:0] a, input logic [9:0] v);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = v;
    #1;
    while (!bus_ready) begin @(negedge clk); #1; end
    last_set = pend_set_valid; last_set_id = pend_set_id;
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0;
    last_busy = !bus_ready;
    if (last_set) pend_m[last_set_id[2:0]] = 1'b1;
  endtask

  task automatic claim(input string tag, input logic [9:0] exp_id);
    logic [9:0] d;
    rd(3'd3, d);
    chk(tag, d, exp_id);
    chk("R11 clear request count", last_clr, exp_id != 10'd1023);
    if (exp_id != 10'd1023) begin
      exp_acks++;
      chk("R11 clear id", last_clr_id, exp_id);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [9:0] d;
    int ord [6][3];
    logic [9:0] nid [3];
    logic [7:0] npr [3];
    ord = '{'{0,1,2}, '{0,2,1}, '{1,0,2}, '{1,2,0}, '{2,0,1}, '{2,1,0}};
    nid = '{10'd3, 10'd5, 10'd6};
    npr = '{8'h80, 8'h40, 8'h20};
    for (int i = 0; i < NB; i++) prio_m[i] = 8'hFF;
    pend_m = '0; en_m = '1; lvl_m = '0; edge_m = '1; model_m = '0; tgt_m = '1;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, d); chk("R1 control", d, 0);
    rd(3'd1, d); chk("R1 mask", d, 10'h0F0);
    rd(3'd5, d); chk("R1 service prio", d, 10'h100);
    rd(3'd6, d); chk("R1 best", d, 10'd1023);
    chk("R1 irq", irq_o, 0);

    // R2 register map
    wr(3'd0, 10'h3FF); rd(3'd0, d); chk("R2 control bit0 only", d, 1);
    wr(3'd1, 10'h234); rd(3'd1, d); chk("R2 mask 8 bits", d, 10'h034);
    wr(3'd2, 10'h155); rd(3'd2, d); chk("R2 grouping reads 0", d, 0);
    wr(3'd7, 10'h155); rd(3'd7, d); chk("R2 unused reads 0", d, 0);
    wr(3'd5, 10'h033); rd(3'd5, d); chk("R2 service prio read-only", d, 10'h100);
    wr(3'd6, 10'h002); rd(3'd6, d); chk("R2 best read-only", d, 10'd1023);

    // R3 / R4 mask sweep
    pend_m[4] = 1'b1;
    for (int pi = 0; pi < 3; pi++) begin
      logic [7:0] p;
      p = (pi == 0) ? 8'h00 : (pi == 1) ? 8'h7F : 8'hFE;
      prio_m[4] = p;
      for (int m = 0; m < 256; m++) begin
        wr(3'd1, 10'(m));
        rd(3'd6, d);
        chk("R3 best vs mask", d, (p <= 8'(m)) ? 10'd4 : 10'd1023);
        chk("R4 irq vs mask", irq_o, p <= 8'(m));
      end
    end
    wr(3'd0, 10'h000);
    rd(3'd6, d); chk("R3 cpu disabled best", d, 10'd1023);
    chk("R4 cpu disabled irq", irq_o, 0);
    wr(3'd0, 10'h001);

    // R5 / R6 claim
    prio_m[4] = 8'h7F; model_m[4] = 1'b1;
    claim("R6 claim returns id", 10'd4);
    chk("R6 clear all for model 1", last_clr_all, 1);
    rd(3'd5, d); chk("R6 service prio", d, 10'h07F);
    rd(3'd6, d); chk("R6 pending cleared", d, 10'd1023);
    claim("R5 nothing pending", 10'd1023);
    prio_m[1] = 8'h7F; pend_m[1] = 1'b1;
    rd(3'd6, d); chk("R3 equal prio visible", d, 10'd1);
    chk("R4 equal prio no irq", irq_o, 0);
    claim("R5 equal prio refused", 10'd1023);
    rd(3'd5, d); chk("R5 service prio unchanged", d, 10'h07F);
    wr(3'd4, 10'd4);
    rd(3'd5, d); chk("R7 pop to idle", d, 10'h100);
    chk("R4 irq after pop", irq_o, 1);
    claim("R6 claim model 0", 10'd1);
    chk("R6 clear this cpu only", last_clr_all, 0);
    wr(3'd4, 10'd1);
    rd(3'd5, d); chk("R7 pop to idle again", d, 10'h100);

    // R9 / R10 retire corner cases
    prio_m[2] = 8'h10; edge_m[2] = 1'b0; lvl_m[2] = 1'b1;
    wr(3'd4, 10'd2); chk("R9 retire while idle", last_set, 0);
    pend_m[2] = 1'b1;
    claim("R10 claim level source", 10'd2);
    wr(3'd4, 10'd8); chk("R9 out of range no set", last_set, 0);
    rd(3'd5, d); chk("R9 out of range no pop", d, 10'h010);
    wr(3'd4, 10'd1023); chk("R9 spurious no set", last_set, 0);
    rd(3'd5, d); chk("R9 spurious no pop", d, 10'h010);
    wr(3'd4, 10'd2);
    chk("R10 re-pend raised", last_set, 1);
    chk("R10 re-pend id", last_set_id, 10'd2);
    rd(3'd6, d); chk("R10 pending again", d, 10'd2);
    claim("R10 reclaim", 10'd2);
    lvl_m[2] = 1'b0;
    wr(3'd4, 10'd2); chk("R10 line low no set", last_set, 0);
    rd(3'd6, d); chk("R10 line low not pending", d, 10'd1023);
    lvl_m[2] = 1'b1; edge_m[2] = 1'b1; pend_m[2] = 1'b1;
    claim("R10 claim edge", 10'd2);
    wr(3'd4, 10'd2); chk("R10 edge no set", last_set, 0);
    edge_m[2] = 1'b0; pend_m[2] = 1'b1;
    claim("R10 claim for disable", 10'd2);
    en_m[2] = 1'b0;
    wr(3'd4, 10'd2); chk("R10 disabled no set", last_set, 0);
    en_m[2] = 1'b1; pend_m[2] = 1'b1;
    claim("R10 claim for target", 10'd2);
    tgt_m[2] = 1'b0;
    wr(3'd4, 10'd2); chk("R10 untargeted no set", last_set, 0);
    tgt_m[2] = 1'b1; lvl_m[2] = 1'b0; pend_m = '0;

    // R7 / R8 nesting, all retire orders
    wr(3'd1, 10'h0FF);
    for (int k = 0; k < 3; k++) prio_m[nid[k]] = npr[k];
    for (int pi = 0; pi < 6; pi++) begin
      logic alive [3];
      for (int k = 0; k < 3; k++) begin
        alive[k] = 1'b1;
        pend_m[nid[k]] = 1'b1;
        claim("R6 nested claim", nid[k]);
      end
      rd(3'd5, d); chk("R6 nested service prio", d, 10'h020);
      for (int s = 0; s < 3; s++) begin
        int e, top;
        e = ord[pi][s];
        top = -1;
        for (int k = 0; k < 3; k++) if (alive[k]) top = k;
        wr(3'd4, nid[e]);
        chk("R8 stall only for nested retire", last_busy, e != top);
        alive[e] = 1'b0;
        top = -1;
        for (int k = 0; k < 3; k++) if (alive[k]) top = k;
        rd(3'd5, d);
        chk("R7 R8 service prio after retire", d,
            (top < 0) ? 10'h100 : {2'b00, npr[top]});
      end
    end

    chk("R11 total clear requests", clr_count, exp_acks);
    finish_run();
  end
endmodule